// File: doc/BRIEF.md
# UART Bit-Rate Tick Generator

This block derives the timing strobes of a UART from a single reference clock. The reference clock can first pass through an optional divide-by-8 stage. A programmable clock divisor then turns it into a sample strobe, and a second programmable divisor turns every few sample strobes into one bit strobe. The resulting bit rate is the selected clock divided by the product of the clock divisor and one more than the sample divisor.

Software programs three configuration values through a one-cycle write port:
- the prescale enable;
- the 16-bit clock divisor;
- the 8-bit sample divisor.

The divisors are meant to change only while the serial paths are idle. Every valid configuration write restarts all counters, so the new rate starts from a clean phase. The serializers and the receive oversampling logic use the two strobes as clock enables.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the clock divisor is 0, the sample divisor is 4 and prescaling is off, so both `sample_tick` and `bit_tick` stay low.
- R2: With prescaling off and clock divisor CD ≥ 1, `sample_tick` is high in exactly those cycles whose index since the last restart is a multiple of CD. The first cycle after the restart has index 1.
- R3: `bit_tick` is high exactly in every (D+1)-th `sample_tick` cycle, where D is the effective sample divisor. It is never high without `sample_tick`.
- R4: When the prescale enable (bit 0 of a write with `wr_sel`=0) is 1, every period is stretched by a factor of 8. `sample_tick` then fires every 8·CD cycles.
- R5: A clock divisor of 0 stops the generator, and neither strobe is produced.
- R6: A sample divisor below 4 acts as 4.
- R7: A write with `wr_sel` of 0 (mode), 1 (clock divisor, `wr_data[15:0]`) or 2 (sample divisor, `wr_data[7:0]`) does the following:
  - it updates that value;
  - it forces both strobes low in the write cycle;
  - it restarts all counters, so the first strobe after the write comes a full period later.
- R8: With CD ≥ 2, `sample_tick` is one cycle wide, and `bit_tick` is always one cycle wide.
- R9: A write with `wr_sel`=3 is ignored: no value changes, no restart, and the strobes continue without disturbance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 2 | Target: 0 mode, 1 clock divisor, 2 sample divisor, 3 none |
| wr_data | input | 16 | Write data |
| sample_tick | output | 1 | One strobe per clock-divisor period |
| bit_tick | output | 1 | One strobe per bit period |

## Verification
The bench builds the block with its default parameters: a 16-bit clock divisor, an 8-bit sample divisor, a prescale of 8 and a divisor floor of 4. It programs small divisor values such as 1, 2, 3 and 5, so complete bit periods with and without prescaling fit in a few hundred cycles. With these settings the clamp of low sample divisors, divisor rewrites in the middle of a period and the continuous strobe at divisor 1 are all exercised many times.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_CD   = 2'd1,
    SEL_BDIV = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/baud_prescale.sv
module baud_prescale #(
  parameter int PRE_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en_div,
  output logic pre_tick
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (en_div)     cnt <= (cnt == LAST) ? '0 : cnt + PW'(1);
  end

  // pass-through when prescaling is off; gated during a restart
  assign pre_tick = !clr && (en_div ? (cnt == LAST) : 1'b1);
endmodule

// File: rtl/baud_gen_count.sv
module baud_gen_count #(
  parameter int CD_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            step,
  input  logic [CD_W-1:0] cd,
  output logic            tick
);
  logic [CD_W-1:0] cnt;
  logic            run;

  function automatic logic at_end(input logic [CD_W-1:0] c, input logic [CD_W-1:0] lim);
    return c == lim - CD_W'(1);
  endfunction

  assign run  = (cd != '0);
  assign tick = !clr && step && run && at_end(cnt, cd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clr)          cnt <= '0;
    else if (step && run)  cnt <= tick ? '0 : cnt + CD_W'(1);
  end
endmodule

// File: rtl/baud_bit_div.sv
module baud_bit_div #(
  parameter int DIV_W   = 8,
  parameter int DIV_MIN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [DIV_W-1:0] bdiv,
  output logic             tick
);
  localparam logic [DIV_W-1:0] FLOOR = DIV_W'(DIV_MIN);

  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] v);
    return (v < FLOOR) ? FLOOR : v;
  endfunction

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim  = eff_div(bdiv);
  assign tick = !clr && step && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (step)  cnt <= tick ? '0 : cnt + DIV_W'(1);
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int CD_W    = 16,
  parameter int DIV_W   = 8,
  parameter int PRE_DIV = 8,
  parameter int DIV_MIN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [CD_W-1:0] wr_data,
  output logic            sample_tick,
  output logic            bit_tick
);
  import baud_pkg::*;

  cfg_sel_e         sel;
  logic             cfg_wr;
  logic             cfg_pre;
  logic [CD_W-1:0]  cfg_cd;
  logic [DIV_W-1:0] cfg_bdiv;
  logic             pre_tick;

  assign sel    = cfg_sel_e'(wr_sel);
  assign cfg_wr = wr_en && (sel != SEL_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_pre  <= 1'b0;
      cfg_cd   <= '0;
      cfg_bdiv <= DIV_W'(DIV_MIN);
    end else if (cfg_wr) begin
      case (sel)
        SEL_MODE: cfg_pre  <= wr_data[0];
        SEL_CD:   cfg_cd   <= wr_data;
        SEL_BDIV: cfg_bdiv <= wr_data[DIV_W-1:0];
        default:  ;
      endcase
    end
  end

  baud_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .en_div(cfg_pre), .pre_tick(pre_tick)
  );

  baud_gen_count #(.CD_W(CD_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .step(pre_tick), .cd(cfg_cd), .tick(sample_tick)
  );

  baud_bit_div #(.DIV_W(DIV_W), .DIV_MIN(DIV_MIN)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .step(sample_tick), .bdiv(cfg_bdiv), .tick(bit_tick)
  );
endmodule

// File: rtl/baud_tick_chk.sv
module baud_tick_chk #(
  parameter int CD_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_wr,
  input logic            cfg_pre,
  input logic [CD_W-1:0] cfg_cd,
  input logic            pre_tick,
  input logic            sample_tick,
  input logic            bit_tick
);
  assert_bit_on_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);

  assert_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cd == '0) |-> !sample_tick);

  assert_quiet_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |-> (!sample_tick && !bit_tick));

  assert_prescale_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pre && sample_tick) |-> pre_tick);

  assert_sample_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && cfg_cd >= CD_W'(2)) |=> !sample_tick);

  assert_bit_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);
endmodule

bind baud_tick_gen baud_tick_chk #(.CD_W(CD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_pre(cfg_pre), .cfg_cd(cfg_cd),
  .pre_tick(pre_tick), .sample_tick(sample_tick), .bit_tick(bit_tick)
);

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = '0;
  logic        sample_tick, bit_tick;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_cd = 0, m_bdiv = 4, m_pre = 0, k = 0;
  bit done = 0;

  always #5 clk = ~clk;

  baud_tick_gen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  task automatic check(input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s got=%0b exp=%0b at cycle %0d", cur_req, what, act, exp, cycles);
    end
  endtask

  // compared every cycle at the falling edge
  always @(negedge clk) begin
    int period_s, period_b, eff;
    bit exp_s, exp_b, wr_valid;
    if (!done) begin
      cycles++;
      if (!rst_n) begin
        m_cd = 0; m_bdiv = 4; m_pre = 0; k = 0;
        check("sample_tick", sample_tick, 1'b0);
        check("bit_tick", bit_tick, 1'b0);
      end else begin
        wr_valid = wr_en && (wr_sel != 2'd3);
        eff = (m_bdiv < 4) ? 4 : m_bdiv;
        period_s = (m_pre ? 8 : 1) * m_cd;
        period_b = period_s * (eff + 1);
        if (wr_valid) begin
          exp_s = 0; exp_b = 0;
        end else begin
          k++;
          exp_s = (m_cd != 0) && (k % period_s == 0);
          exp_b = (m_cd != 0) && (k % period_b == 0);
        end
        check("sample_tick", sample_tick, exp_s);
        check("bit_tick", bit_tick, exp_b);
        if (wr_valid) begin
          case (wr_sel)
            2'd0: m_pre = int'(wr_data[0]);
            2'd1: m_cd = int'(wr_data);
            default: m_bdiv = int'(wr_data[7:0]);
          endcase
          k = 0;
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic cfg(input logic [1:0] s, input logic [15:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    cur_req = "R1"; step(20);               // reset state: CD=0, no ticks
    cur_req = "R2"; cfg(2'd1, 16'd3); step(80);
    cur_req = "R3"; cfg(2'd2, 16'd5); step(120);
    cur_req = "R6"; cfg(2'd2, 16'd2); step(100);
    cur_req = "R8"; cfg(2'd1, 16'd2); step(60);
    cur_req = "R8"; cfg(2'd1, 16'd1); step(40);
    cur_req = "R4"; cfg(2'd1, 16'd3); cfg(2'd0, 16'd1); step(400);
    cur_req = "R7"; step(7); cfg(2'd1, 16'd2); step(5); cfg(2'd2, 16'd4); step(200);
    cur_req = "R9"; cfg(2'd0, 16'd0); step(9); cfg(2'd3, 16'hFFFF); step(60);
    cur_req = "R5"; cfg(2'd1, 16'd0); step(100);
    cur_req = "R2"; cfg(2'd1, 16'd7); step(150);
    finish_run();
  end

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog expired after %0d cycles", cycles);
    finish_run();
  end
endmodule